// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM read or write burst. A single-cycle start strobe captures the starting column, the burst-length code and the wrap order. From the next cycle the block presents one column per clock, with a valid flag and a flag that marks the final beat of a fixed-length burst. Data, command decoding and bank or row handling stay with the surrounding controller.

Sequential order counts up inside the aligned block that the burst length defines. Interleaved order combines the start column with the beat number by exclusive OR. A full-page burst covers every column of the row, wraps around and runs until a terminate request ends it. The output stream has no ready input. Flow control comes from the clock-enable input instead. A low clock-enable sample freezes the burst from the following clock, and the consumer sees the same column and flags for as long as the freeze lasts. The stream resumes one clock after clock enable is sampled high again. A start or terminate request that arrives while the block is frozen has no effect.

Top module: `sdr_colgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `valid` and `last` are low.
- R2: A start sampled on an enabled clock edge makes `valid` high after that edge, with `col` equal to the captured start column. A start during a running burst discards that burst and begins the new one, and it takes priority over `term` in the same cycle.
- R3: When `order_ilv` is 0 (sequential; this is mode bit 3 of the device), beat n shows the start column with its low log2(L) bits replaced by (start + n) mod L. The upper bits do not change.
- R4: When `order_ilv` is 1 (interleaved), beat n shows the start column XOR n, with n confined to the low log2(L) bits.
- R5: `len_code` (mode bits 2:0) gives the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Codes 100, 101 and 110 give 1 beat. After the final beat, `valid` is low.
- R6: Code 111 selects full page. The column wraps modulo 256 (the 8-bit column space), and the burst continues until `term` is sampled on an enabled edge. `valid` is low after that edge.
- R7: `last` is high exactly on the final beat of a fixed-length burst. It is never high in full-page mode, and never high while `valid` is low.
- R8: When `cke` is sampled low at edge k, edge k still acts. Every following edge leaves `col`, `valid` and `last` unchanged until the edge after `cke` is next sampled high.
- R9: `term` sampled on an enabled edge ends a fixed-length burst early, and `valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the burst from the next clock |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst-length code (mode bits 2:0) |
| order_ilv | input | 1 | 0 sequential, 1 interleaved (mode bit 3) |
| term | input | 1 | Burst terminate request |
| col | output | COL_W | Current column address |
| valid | output | 1 | A column is presented this cycle |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Sequential bursts are started from columns near the top of their aligned block, so that the wrap is visible, and from near the top of the column space. A missing mask then shows up as a carry into the upper bits. Interleaved bursts of length 2, 4 and 8 start from columns with mixed low bits, which tells exclusive-OR order apart from a count. Every length code is tried, including the three that fall back to one beat. Full-page bursts run past column 255 before they are terminated, and clock-enable gaps in the middle of a burst, together with starts and terminates issued during a freeze, separate the one-cycle-delayed freeze from both an immediate freeze and no freeze at all.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;
  localparam int CODE_W = 3;
  localparam int MAX_FIXED_LG = 3;
  localparam logic [CODE_W-1:0] CODE_FULL_PAGE = 3'b111;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/sdr_colgen_decode.sv
module sdr_colgen_decode
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [CODE_W-1:0] len_code,
  output logic [COL_W-1:0]  wrap_mask,
  output logic              full_page
);
  logic [1:0] lg;

  always_comb begin
    full_page = (len_code == CODE_FULL_PAGE);
    lg = len_code[2] ? 2'd0 : len_code[1:0];
    wrap_mask = '0;
    if (full_page) begin
      wrap_mask = '1;
    end else begin
      for (int i = 0; i < MAX_FIXED_LG; i++) begin
        if (i < int'(lg)) wrap_mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr_colgen_seq.sv
module sdr_colgen_seq
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  order_e           order_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output order_e           order,
  output logic             at_end
);
  logic cke_q;
  logic full;

  assign at_end = !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      active <= 1'b0;
      beat   <= '0;
      base   <= '0;
      mask   <= '0;
      full   <= 1'b0;
      order  <= ORD_SEQ;
    end else begin
      cke_q <= cke;
      if (cke_q) begin
        if (start) begin
          active <= 1'b1;
          beat   <= '0;
          base   <= start_col;
          mask   <= mask_in;
          full   <= full_in;
          order  <= order_in;
        end else if (active) begin
          if (term || at_end) active <= 1'b0;
          else                beat   <= beat + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdr_colgen_map.sv
module sdr_colgen_map
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic wrapped;
    assign wrapped = (order == ORD_ILV) ? (base[i] ^ beat[i]) : sum[i];
    assign col[i]  = mask[i] ? wrapped : base[i];
  end
endmodule

// File: rtl/sdr_colgen.sv
module sdr_colgen
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             order_ilv,
  input  logic             term,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             active;
  logic             at_end;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] mask;
  order_e           order;

  sdr_colgen_decode #(.COL_W(COL_W)) u_decode (
    .len_code (len_code),
    .wrap_mask(dec_mask),
    .full_page(dec_full)
  );

  sdr_colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .start    (start),
    .term     (term),
    .start_col(start_col),
    .mask_in  (dec_mask),
    .full_in  (dec_full),
    .order_in (order_ilv ? ORD_ILV : ORD_SEQ),
    .active   (active),
    .beat     (beat),
    .base     (base),
    .mask     (mask),
    .order    (order),
    .at_end   (at_end)
  );

  sdr_colgen_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .beat (beat),
    .mask (mask),
    .order(order),
    .col  (col)
  );

  assign valid = active;
  assign last  = active && at_end;
endmodule

// File: rtl/sdr_colgen_chk.sv
module sdr_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             order_ilv,
  input logic             term,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last
);
  logic ck_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) ck_prev <= 1'b1;
    else        ck_prev <= cke;
  end

  // R1: reset leaves the stream idle
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !valid && !last);

  // R2: an accepted start shows its column on the next cycle
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start && ck_prev |=> valid && col == $past(start_col));

  // R5: the final beat of a fixed burst is followed by idle
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last && ck_prev && !start |=> !valid);

  // R7: last only on a presented beat
  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  // R8: a low clock-enable sample freezes the following edge
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_prev |=> $stable(col) && $stable(valid) && $stable(last));

  // R9: terminate on an enabled edge ends the burst
  a_r9_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
    valid && term && !start && ck_prev |=> !valid);
endmodule

bind sdr_colgen sdr_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdr_colgen_tb.sv
module sdr_colgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       order_ilv = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       valid;
  logic       last;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int m_act = 0, m_beat = 0, m_start = 0, m_len = 1, m_ilv = 0, m_ck = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
    .start_col(start_col), .len_code(len_code), .order_ilv(order_ilv),
    .term(term), .col(col), .valid(valid), .last(last)
  );

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int msk, c;
    msk = (m_len == 0) ? 255 : m_len - 1;
    if (m_ilv != 0) return m_start ^ (m_beat & msk);
    c = m_start;
    for (int k = 0; k < m_beat; k++) begin
      if ((c & msk) == msk) c = c & ~msk & 255;
      else                  c = c + 1;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_act = 0; m_beat = 0; m_ck = 1;
    end else begin
      if (m_ck != 0) begin
        if (start) begin
          m_act = 1; m_beat = 0; m_start = int'(start_col);
          m_len = code_len(len_code); m_ilv = int'(order_ilv);
        end else if (m_act != 0) begin
          if (term || (m_len != 0 && m_beat == m_len - 1)) m_act = 0;
          else m_beat = (m_beat + 1) % 256;
        end
      end
      m_ck = int'(cke);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int ev, el;
    ev = m_act;
    el = (m_act != 0 && m_len != 0 && m_beat == m_len - 1) ? 1 : 0;
    check(tag, "valid", int'(valid), ev);
    check((tag == "R1") ? "R1" : "R7", "last", int'(last), el);
    if (ev != 0) check(tag, "col", int'(col), exp_col());
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic kick(input int c, input logic [2:0] code, input logic ilv);
    @(negedge clk);
    start = 1'b1; start_col = 8'(c); len_code = code; order_ilv = ilv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic burst(input int c, input logic [2:0] code, input logic ilv,
                       input int n_exp, input string req);
    int n = 0;
    tag = req;
    kick(c, code, ilv);
    while (valid && n < 400) begin
      n++;
      @(negedge clk);
    end
    check(req, "beat count", n, n_exp);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(valid), 0);

    // R2 / R3 sequential, wrap inside aligned block
    tag = "R2";
    @(negedge clk); start = 1; start_col = 8'h0E; len_code = 3'b010; order_ilv = 0;
    @(negedge clk); start = 0;
    check("R2", "first column", int'(col), 'h0E);
    while (valid) @(negedge clk);
    burst('h0E, 3'b010, 1'b0, 4, "R3");
    burst('hFB, 3'b011, 1'b0, 8, "R3");
    burst('h41, 3'b001, 1'b0, 2, "R3");

    // R4 interleaved
    burst('h35, 3'b011, 1'b1, 8, "R4");
    burst('h96, 3'b010, 1'b1, 4, "R4");
    burst('h03, 3'b001, 1'b1, 2, "R4");

    // R5 every code
    for (int k = 0; k < 7; k++)
      burst(17 * k + 5, 3'(k), 1'(k % 2), code_len(3'(k)), "R5");

    // R6 full page wraps past 255, ended by term
    tag = "R6";
    kick('hF0, 3'b111, 1'b0);
    repeat (270) @(negedge clk);
    check("R6", "still running", int'(valid), 1);
    check("R7", "no last in full page", int'(last), 0);
    term = 1; @(negedge clk); term = 0;
    check("R6", "ended by term", int'(valid), 0);
    kick('h5A, 3'b111, 1'b1);
    repeat (20) @(negedge clk);
    term = 1; @(negedge clk); term = 0;
    check("R6", "interleaved page ended", int'(valid), 0);

    // R8 freeze with clock enable
    tag = "R8";
    kick('h1D, 3'b011, 1'b0);
    @(negedge clk);
    cke = 0;
    repeat (4) @(negedge clk);
    term = 1; start = 1; start_col = 8'h77;  // ignored while frozen
    @(negedge clk);
    term = 0; start = 0;
    check("R8", "term ignored while frozen", int'(valid), 1);
    cke = 1;
    begin
      int n = 0;
      while (valid && n < 40) begin n++; @(negedge clk); end
      check("R8", "remaining beats", n, 7);
    end
    cke = 0; @(negedge clk); cke = 1;
    burst('h2C, 3'b010, 1'b1, 4, "R8");

    // R9 early terminate and restart
    tag = "R9";
    kick('h80, 3'b011, 1'b0);
    repeat (2) @(negedge clk);
    term = 1; @(negedge clk); term = 0;
    check("R9", "early end", int'(valid), 0);
    tag = "R2";
    kick('h10, 3'b011, 1'b0);
    @(negedge clk);
    start = 1; term = 1; start_col = 8'hC4; len_code = 3'b001; order_ilv = 1;
    @(negedge clk);
    start = 0; term = 0;
    check("R2", "restart column", int'(col), 'hC4);
    while (valid) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule